// File: doc/BRIEF.md
# Multi-Format Stereo Audio Serial Receiver

This block takes a stereo PCM stream carried on three wires: a bit clock, a frame clock that marks which channel is being sent, and a serial data line. It turns each channel's sample into a 24-bit two's-complement word. The bit clock is the block's clock, and every data bit is taken on its rising edge. A 2-bit format input picks one of four framings. Two are right-justified, with 16-bit or 24-bit samples. One is left-justified with 24-bit samples. The fourth is I2S-style, where the sample starts one bit clock after the frame-clock transition.

Once a full left/right pair has arrived, the block presents the two words together with a one-cycle valid pulse. Each completed half-frame is also measured: if it held too few bit clocks for the selected format, a one-cycle error pulse is raised. 16-bit samples are left-aligned in the 24-bit outputs, with the low byte zero.

Top module: `stereo_ser_rx`

## Requirements
- R1: With fmt = 00, the sample is the last 16 bits of each half-frame, MSB first. It is output as {sample, 8'h00}.
- R2: With fmt = 01, the sample is the last 24 bits of each half-frame, MSB first.
- R3: With fmt = 10, the sample is the first 24 bits of each half-frame. The MSB is the bit taken on the first rising bit clock at which the frame clock shows its new level.
- R4: With fmt = 11, the MSB is the bit one bit clock after the frame-clock transition. A half-frame of exactly 16 bit clocks gives a 16-bit sample, output as {sample, 8'h00}. A half-frame of 24 or more gives the first 24 bits.
- R5: In formats 00, 01 and 10, frame clock high carries the left channel. In format 11, frame clock low carries the left channel.
- R6: Bits outside the sample window of a half-frame do not affect the outputs. These are the leading bits in the right-justified formats and the trailing bits in the left-justified and I2S formats.
- R7: valid_o pulses for exactly one cycle per frame, when the right half-frame that follows a left half-frame ends. left_o and right_o change only on that cycle.
- R8: err_o pulses for one cycle at the end of every half-frame whose bit-clock count is below the minimum for its format. The minimum is 16 for fmt 00 and 24 for fmt 01 and 10. With fmt 11, the count must be exactly 16 or at least 24.
- R9: Reset sets left_o and right_o to zero and clears valid_o and err_o. The partial half-frame that is in progress when reset is released is neither reported nor checked.
- R10: Sample words pass through unchanged as two's complement, including full-scale 7FFFFF and 800000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial bit clock; data is sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| fmt | input | 2 | Framing select: 00 RJ16, 01 RJ24, 10 LJ24, 11 I2S |
| lrck | input | 1 | Frame clock; its level marks the channel |
| sdata | input | 1 | Serial sample data, MSB first |
| left_o | output | 24 | Last left-channel sample word |
| right_o | output | 24 | Last right-channel sample word |
| valid_o | output | 1 | One-cycle pulse when a new left/right pair is presented |
| err_o | output | 1 | One-cycle pulse after a half-frame that was too short |

## Verification
Each format is driven at its minimum half-frame length and at a longer one, with the unused bit slots toggling. A result that depends on the don't-care bits, or an off-by-one in the justification, therefore shows up as a wrong word. Left and right values are always different, and some are full-scale or asymmetric, so a swapped channel polarity or a sign error cannot hide. Each format is also driven with half-frames shorter than it allows, including an I2S length between 16 and 24, and the number of error pulses must match the number of completed halves exactly. A separate run releases reset partway through a half-frame, to show that the partial half is discarded.

// File: rtl/ssrx_pkg.sv
package ssrx_pkg;
  typedef enum logic [1:0] {
    FMT_RJ16 = 2'b00,
    FMT_RJ24 = 2'b01,
    FMT_LJ24 = 2'b10,
    FMT_I2S  = 2'b11
  } fmt_e;
endpackage

// File: rtl/ssrx_framer.sv
module ssrx_framer
  import ssrx_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  fmt_e fmt,
  input  logic lrck,
  output logic start,
  output logic half_end,
  output logic done_left
);
  // side = 1 means left channel, after the I2S delay and polarity are applied
  logic       lrck_q;
  logic       side_q;
  logic       synced;
  logic [1:0] warm;
  logic       side_now;

  always_comb side_now = (fmt == FMT_I2S) ? ~lrck_q : lrck;

  assign start     = (warm == 2'd2) && (side_now != side_q);
  assign half_end  = start && synced;
  assign done_left = side_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lrck_q <= 1'b0;
      side_q <= 1'b0;
      synced <= 1'b0;
      warm   <= 2'd0;
    end else begin
      lrck_q <= lrck;
      side_q <= side_now;
      if (warm != 2'd2) warm <= warm + 2'd1;
      if (start) synced <= 1'b1;
    end
  end

  AST_JUST_EDGE: assert property (@(posedge clk) disable iff (rst)
    (start && fmt != FMT_I2S && $past(fmt) != FMT_I2S) |-> (lrck != $past(lrck))); // R5

  AST_I2S_LAG: assert property (@(posedge clk) disable iff (rst)
    (start && fmt == FMT_I2S && $past(fmt) == FMT_I2S) |-> ($past(lrck) != $past(lrck, 2))); // R4
endmodule

// File: rtl/ssrx_shift.sv
module ssrx_shift #(
  parameter int SAMPLE_W = 24,
  parameter int CNT_W    = 8,
  localparam int HN_W    = $clog2(SAMPLE_W + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sdata,
  input  logic                start,
  output logic [SAMPLE_W-1:0] tail,
  output logic [SAMPLE_W-1:0] head,
  output logic [HN_W-1:0]     head_n,
  output logic [CNT_W-1:0]    cnt
);
  localparam logic [HN_W-1:0]  HEAD_MAX = HN_W'(SAMPLE_W);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      tail   <= '0;
      head   <= '0;
      head_n <= '0;
      cnt    <= '0;
    end else begin
      // tail always holds the most recent bits (right-justified view)
      tail <= {tail[SAMPLE_W-2:0], sdata};
      if (start) begin
        head   <= {{(SAMPLE_W-1){1'b0}}, sdata};
        head_n <= HN_W'(1);
        cnt    <= CNT_W'(1);
      end else begin
        if (head_n < HEAD_MAX) begin
          head   <= {head[SAMPLE_W-2:0], sdata};
          head_n <= head_n + HN_W'(1);
        end
        if (cnt != CNT_MAX) cnt <= cnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/ssrx_assemble.sv
module ssrx_assemble
  import ssrx_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int SHORT_W  = 16,
  parameter int CNT_W    = 8,
  localparam int HN_W    = $clog2(SAMPLE_W + 1),
  localparam int PAD_W   = SAMPLE_W - SHORT_W
) (
  input  logic                clk,
  input  logic                rst,
  input  fmt_e                fmt,
  input  logic                half_end,
  input  logic                done_left,
  input  logic [SAMPLE_W-1:0] tail,
  input  logic [SAMPLE_W-1:0] head,
  input  logic [HN_W-1:0]     head_n,
  input  logic [CNT_W-1:0]    cnt,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                valid_o,
  output logic                err_o
);
  localparam logic [CNT_W-1:0] MIN_SHORT = CNT_W'(SHORT_W);
  localparam logic [CNT_W-1:0] MIN_LONG  = CNT_W'(SAMPLE_W);
  localparam logic [HN_W-1:0]  HEAD_MAX  = HN_W'(SAMPLE_W);

  logic [SAMPLE_W-1:0] word;
  logic                short_half;
  logic [SAMPLE_W-1:0] left_hold;
  logic                have_left;

  always_comb begin
    unique case (fmt)
      FMT_RJ16: word = {tail[SHORT_W-1:0], {PAD_W{1'b0}}};
      FMT_RJ24: word = tail;
      default:  word = head << (HEAD_MAX - head_n);
    endcase
  end

  always_comb begin
    unique case (fmt)
      FMT_RJ16: short_half = (cnt < MIN_SHORT);
      FMT_I2S:  short_half = (cnt < MIN_SHORT) || ((cnt > MIN_SHORT) && (cnt < MIN_LONG));
      default:  short_half = (cnt < MIN_LONG);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      left_o    <= '0;
      right_o   <= '0;
      left_hold <= '0;
      have_left <= 1'b0;
      valid_o   <= 1'b0;
      err_o     <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      err_o   <= 1'b0;
      if (half_end) begin
        err_o <= short_half;
        if (done_left) begin
          left_hold <= word;
          have_left <= 1'b1;
        end else if (have_left) begin
          left_o    <= left_hold;
          right_o   <= word;
          valid_o   <= 1'b1;
          have_left <= 1'b0;
        end
      end
    end
  end

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o); // R7

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> ($stable(left_o) && $stable(right_o))); // R7

  AST_ERR_AT_END: assert property (@(posedge clk) disable iff (rst)
    err_o |-> $past(half_end)); // R8

  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (valid_o && $past(fmt) == FMT_RJ16) |-> (right_o[PAD_W-1:0] == '0)); // R1
endmodule

// File: rtl/stereo_ser_rx.sv
module stereo_ser_rx
  import ssrx_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int SHORT_W  = 16,
  parameter int CNT_W    = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          fmt,
  input  logic                lrck,
  input  logic                sdata,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                valid_o,
  output logic                err_o
);
  localparam int HN_W = $clog2(SAMPLE_W + 1);

  fmt_e                fmt_sel;
  logic                start;
  logic                half_end;
  logic                done_left;
  logic [SAMPLE_W-1:0] tail;
  logic [SAMPLE_W-1:0] head;
  logic [HN_W-1:0]     head_n;
  logic [CNT_W-1:0]    cnt;

  assign fmt_sel = fmt_e'(fmt);

  ssrx_framer u_framer (
    .clk       (clk),
    .rst       (rst),
    .fmt       (fmt_sel),
    .lrck      (lrck),
    .start     (start),
    .half_end  (half_end),
    .done_left (done_left)
  );

  ssrx_shift #(
    .SAMPLE_W (SAMPLE_W),
    .CNT_W    (CNT_W)
  ) u_shift (
    .clk    (clk),
    .rst    (rst),
    .sdata  (sdata),
    .start  (start),
    .tail   (tail),
    .head   (head),
    .head_n (head_n),
    .cnt    (cnt)
  );

  ssrx_assemble #(
    .SAMPLE_W (SAMPLE_W),
    .SHORT_W  (SHORT_W),
    .CNT_W    (CNT_W)
  ) u_assemble (
    .clk       (clk),
    .rst       (rst),
    .fmt       (fmt_sel),
    .half_end  (half_end),
    .done_left (done_left),
    .tail      (tail),
    .head      (head),
    .head_n    (head_n),
    .cnt       (cnt),
    .left_o    (left_o),
    .right_o   (right_o),
    .valid_o   (valid_o),
    .err_o     (err_o)
  );
endmodule

// File: tb/stereo_ser_rx_bench.sv
module stereo_ser_rx_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  fmt = 2'b00;
  logic        lrck = 1'b0;
  logic        sdata = 1'b0;
  logic [23:0] left_o, right_o;
  logic        valid_o, err_o;

  int tests = 0;
  int fails = 0;
  int vcnt = 0;
  int ecnt = 0;
  int vlong = 0;
  logic prev_v = 1'b0;
  logic [23:0] got_l = '0, got_r = '0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  stereo_ser_rx u_stereo_ser_rx (
    .clk(clk), .rst(rst), .fmt(fmt), .lrck(lrck), .sdata(sdata),
    .left_o(left_o), .right_o(right_o), .valid_o(valid_o), .err_o(err_o)
  );

  always @(negedge clk) begin
    if (valid_o) begin
      vcnt++;
      got_l = left_o;
      got_r = right_o;
      if (prev_v) vlong++;
    end
    if (err_o) ecnt++;
    prev_v = valid_o;
  end

  typedef struct packed {
    logic [1:0]  f;
    logic [7:0]  h;
    logic [23:0] l;
    logic [23:0] r;
    logic        e;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 8'd16, 24'h123456, 24'h80FF00, 1'b0, 4'd1},  // R1
    '{2'd0, 8'd32, 24'h7FFF00, 24'hFFFF00, 1'b0, 4'd6},  // R6 leading junk
    '{2'd1, 8'd24, 24'h7FFFFF, 24'h800000, 1'b0, 4'd10}, // R10
    '{2'd1, 8'd32, 24'hABCDEF, 24'h012345, 1'b0, 4'd2},  // R2
    '{2'd2, 8'd24, 24'h5A5A5A, 24'hA5A5A5, 1'b0, 4'd3},  // R3
    '{2'd2, 8'd40, 24'hC0FFEE, 24'h13579B, 1'b0, 4'd6},  // R6 trailing junk
    '{2'd3, 8'd16, 24'hBEEF77, 24'h000100, 1'b0, 4'd4},  // R4 16-bit
    '{2'd3, 8'd32, 24'h123456, 24'hFEDCBA, 1'b0, 4'd4},  // R4 24-bit
    '{2'd3, 8'd24, 24'h800001, 24'h7FFFFE, 1'b0, 4'd5},  // R5 I2S polarity
    '{2'd0, 8'd24, 24'h0F0F00, 24'hF0F000, 1'b0, 4'd5},  // R5 justified polarity
    '{2'd1, 8'd16, 24'h111111, 24'h222222, 1'b1, 4'd8},  // R8
    '{2'd0, 8'd12, 24'h333300, 24'h444400, 1'b1, 4'd8},  // R8
    '{2'd3, 8'd20, 24'h555555, 24'h666666, 1'b1, 4'd8},  // R8 I2S gap
    '{2'd2, 8'd20, 24'h777777, 24'h888888, 1'b1, 4'd8}   // R8
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_frame(input logic [1:0] f, input int h, input logic [23:0] lv, input logic [23:0] rv);
    for (int p = 0; p < 2*h; p++) begin
      int idx;
      int i;
      logic [23:0] v;
      logic lr;
      logic b;
      b = p[0];
      if (f == 2'd3) begin
        lr  = (p >= h);
        idx = (p + 2*h - 1) % (2*h);
        v   = (idx < h) ? lv : rv;
        i   = idx % h;
        if (i < ((h == 16) ? 16 : 24)) b = v[23-i];
      end else begin
        lr = (p < h);
        v  = (p < h) ? lv : rv;
        i  = p % h;
        if (f == 2'd0) begin
          if (i >= h - 16) b = v[23 - i + h - 16];
        end else if (f == 2'd1) begin
          if (i >= h - 24) b = v[h - 1 - i];
        end else begin
          if (i < 24) b = v[23 - i];
        end
      end
      @(negedge clk);
      lrck  = lr;
      sdata = b;
    end
  endtask

  task automatic do_reset(input logic [1:0] f, input logic lvl);
    @(negedge clk);
    rst = 1'b1; fmt = f; lrck = lvl; sdata = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R9 reset state
    chk("R9 left after reset", {8'h0, left_o}, 32'h0);
    chk("R9 right after reset", {8'h0, right_o}, 32'h0);
    chk("R9 valid/err after reset", {30'h0, valid_o, err_o}, 32'h0);

    for (int k = 0; k < NV; k++) begin
      vec_t vv;
      int v0, e0;
      logic [23:0] el, er;
      string tag;
      vv  = VECS[k];
      tag = $sformatf("R%0d vec%0d", vv.req, k);
      do_reset(vv.f, (vv.f == 2'd3));
      v0 = vcnt; e0 = ecnt;
      repeat (3) send_frame(vv.f, int'(vv.h), vv.l, vv.r);
      repeat (4) @(negedge clk);
      if (vv.e) begin
        chk({tag, " error pulses"}, ecnt - e0, 5);
      end else begin
        el = (vv.f == 2'd0 || (vv.f == 2'd3 && vv.h == 8'd16)) ? {vv.l[23:8], 8'h0} : vv.l;
        er = (vv.f == 2'd0 || (vv.f == 2'd3 && vv.h == 8'd16)) ? {vv.r[23:8], 8'h0} : vv.r;
        chk({tag, " left"}, {8'h0, got_l}, {8'h0, el});
        chk({tag, " right"}, {8'h0, got_r}, {8'h0, er});
        chk({tag, " R7 valid count"}, vcnt - v0, 2);
        chk({tag, " no error"}, ecnt - e0, 0);
      end
    end

    // R7 valid never wider than one cycle
    chk("R7 valid pulse width", vlong, 0);

    // R9 reset mid-stream clears outputs
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 left cleared", {8'h0, left_o}, 32'h0);
    chk("R9 right cleared", {8'h0, right_o}, 32'h0);

    // R9 partial half at reset release is discarded
    begin
      int v0, e0;
      do_reset(2'd1, 1'b1);
      v0 = vcnt; e0 = ecnt;
      repeat (3) send_frame(2'd1, 24, 24'h9ABCDE, 24'h246813);
      repeat (4) @(negedge clk);
      chk("R9 partial half not paired", vcnt - v0, 1);
      chk("R9 partial half not checked", ecnt - e0, 0);
      chk("R9 pair after partial left", {8'h0, got_l}, 32'h009ABCDE);
      chk("R9 pair after partial right", {8'h0, got_r}, 32'h00246813);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule